// File: doc/BRIEF.md
# Split-Access 64-bit Register Adapter

This block lets a bus that carries only 32 bits reach a bank of 64-bit control and status registers. Every 64-bit register takes two 32-bit bus accesses, and one shared 32-bit holding latch makes each pair act as a single atomic 64-bit access.

Writing the lower half only fills the latch. Writing the upper half joins the bus data with the latch and commits all 64 bits to the bank in one strobe. Reading the lower half reads all 64 bits from the bank in one strobe, returns the low word and keeps the high word in the latch. Reading the upper half is then served from that snapshot, so the two halves come from the same instant even if the register has changed since.

Each request is given in one cycle with `reqValid` high. The bank answers in the same cycle. The response appears one cycle later on `rspValid`, `rspData` and `rspErr`. A bank error is only passed back to the bus, with no other handling.

Top module: `split_csr_adapter`

## Requirements
- R1: After reset the holding latch is zero, `rspValid` is 0, `rspData` is 0 and `rspErr` is 0. A read of an upper half made before any other access returns 0.
- R2: A write whose address bit 2 is 0 loads `reqWdata` into the latch and raises neither `bankRd` nor `bankWr`.
- R3: A write whose address bit 2 is 1 raises `bankWr` for exactly that request cycle. In that cycle `bankWdata` is {`reqWdata`, latch}, with the bus data in bits 63:32, and `bankAddr` equals `reqAddr` with bit 2 cleared.
- R4: A read whose address bit 2 is 0 raises `bankRd` for that request cycle with `bankAddr` = `reqAddr` with bit 2 cleared. It returns `bankRdata[31:0]` and loads `bankRdata[63:32]` into the latch.
- R5: A read whose address bit 2 is 1 raises no bank strobe and returns the current latch value.
- R6: The same latch serves reads and writes at every register address. A lower-half read followed by an upper-half write commits the upper word captured by that read in bits 31:0. A lower-half write followed by an upper-half read returns the written word.
- R7: `rspValid` is high in the cycle after each request and at no other time. `rspData` is updated only by reads.
- R8: After a lower-half read, changing the bank register does not change what the following upper-half read returns.
- R9: `rspErr` equals `bankErr` sampled in the request cycle when that request strobed the bank, and is 0 for requests that touched only the latch.
- R10: `bankRd` and `bankWr` are never high together, and neither is high without `reqValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request in this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Byte address; bit 2 selects the upper half |
| reqWdata | input | 32 | Write data for the selected half |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspData | output | 32 | Read data |
| rspErr | output | 1 | Bank error passed back to the bus |
| bankAddr | output | ADDR_W | Register address with bit 2 cleared |
| bankRd | output | 1 | One-cycle 64-bit read strobe |
| bankWr | output | 1 | One-cycle 64-bit write strobe |
| bankWdata | output | 64 | 64-bit write value |
| bankRdata | input | 64 | 64-bit read value, same cycle as `bankRd` |
| bankErr | input | 1 | Bank error for the strobed access |

## Verification
Some checks run on every cycle. These confirm that the two strobes never overlap and that a response follows each request and only a request. They also confirm that the latch changes only when a half access loads it, that a lower-half read leaves the bank's upper word in the latch, and that an upper-half read returns the latch value. Other behaviour needs ordered sequences of accesses, so only the directed scenarios can show it. Those scenarios cover the 64-bit value built from two writes, the address with bit 2 cleared reaching the bank, the returned snapshot staying the same after the bank is changed underneath, and the latch shared between reads and writes.

// File: rtl/split_csr_pkg.sv
package split_csr_pkg;
  typedef struct packed {
    logic bankRd;         // 64-bit read strobe toward bank
    logic bankWr;         // 64-bit write strobe toward bank
    logic latchFromBus;   // low-half write buffers bus data
    logic latchFromBank;  // low-half read snapshots upper word
    logic rdLoad;         // read response data update
    logic rdFromLatch;    // read served from the latch
    logic errCapture;     // request touched the bank
  } ctrlStrb_t;
endpackage

// File: rtl/split_csr_ctrl.sv
module split_csr_ctrl
  import split_csr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      reqHigh,
  output ctrlStrb_t strb,
  output logic      rspValid
);
  always_comb begin
    strb = '0;
    if (reqValid) begin
      strb.bankWr        = reqWrite && reqHigh;
      strb.bankRd        = !reqWrite && !reqHigh;
      strb.latchFromBus  = reqWrite && !reqHigh;
      strb.latchFromBank = !reqWrite && !reqHigh;
      strb.rdLoad        = !reqWrite;
      strb.rdFromLatch   = !reqWrite && reqHigh;
      strb.errCapture    = reqWrite == reqHigh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R10
  strobeExclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.bankRd && strb.bankWr));
  // R10
  strobeNeedsReq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bankRd || strb.bankWr) |-> reqValid);
  // R7
  rspFollowsReq_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R7
  rspOnlyAfterReq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/split_csr_dpath.sv
module split_csr_dpath
  import split_csr_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [HALF_W-1:0] wrHalf,
  input  logic [WORD_W-1:0] bankRdata,
  input  logic              bankErr,
  output logic [WORD_W-1:0] bankWdata,
  output logic [HALF_W-1:0] rspData,
  output logic              rspErr
);
  logic [HALF_W-1:0] latchQ;

  assign bankWdata = {wrHalf, latchQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ  <= '0;
      rspData <= '0;
      rspErr  <= 1'b0;
    end else begin
      if (strb.latchFromBus)       latchQ <= wrHalf;
      else if (strb.latchFromBank) latchQ <= bankRdata[WORD_W-1:HALF_W];
      if (strb.rdLoad)
        rspData <= strb.rdFromLatch ? latchQ : bankRdata[HALF_W-1:0];
      rspErr <= strb.errCapture && bankErr;
    end
  end

  // R6
  latchHolds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.latchFromBus && !strb.latchFromBank) |=> $stable(latchQ));
  // R4
  snapshotUpper_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchFromBank |=> latchQ == $past(bankRdata[WORD_W-1:HALF_W]));
  // R5
  highReadFromLatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLoad && strb.rdFromLatch) |=> rspData == $past(latchQ));
  // R2
  lowWriteBuffers_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchFromBus |=> latchQ == $past(wrHalf));
endmodule

// File: rtl/split_csr_adapter.sv
module split_csr_adapter
  import split_csr_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int HALF_W       = 32,
  parameter int HALF_SEL_BIT = 2,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [HALF_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [HALF_W-1:0] rspData,
  output logic              rspErr,
  output logic [ADDR_W-1:0] bankAddr,
  output logic              bankRd,
  output logic              bankWr,
  output logic [WORD_W-1:0] bankWdata,
  input  logic [WORD_W-1:0] bankRdata,
  input  logic              bankErr
);
  localparam logic [ADDR_W-1:0] HALF_MASK = ADDR_W'(1) << HALF_SEL_BIT;

  ctrlStrb_t strb;

  assign bankAddr = reqAddr & ~HALF_MASK;
  assign bankRd   = strb.bankRd;
  assign bankWr   = strb.bankWr;

  split_csr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqHigh  (reqAddr[HALF_SEL_BIT]),
    .strb     (strb),
    .rspValid (rspValid)
  );

  split_csr_dpath #(.HALF_W(HALF_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrHalf    (reqWdata),
    .bankRdata (bankRdata),
    .bankErr   (bankErr),
    .bankWdata (bankWdata),
    .rspData   (rspData),
    .rspErr    (rspErr)
  );
endmodule

// File: tb/split_csr_adapter_test.sv
module split_csr_adapter_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspErr, bankRd, bankWr;
  logic [31:0] rspData;
  logic [ADDR_W-1:0] bankAddr;
  logic [63:0] bankWdata, bankRdata;
  logic        bankErr = 1'b0;
  logic [63:0] bankMem [8];

  int checks = 0, fails = 0;
  logic seenRd, seenWr, seenBoth;
  logic [ADDR_W-1:0] seenAddr;
  logic [63:0] seenWdata;
  logic [31:0] gotData;
  logic gotErr, gotValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_csr_adapter uut (.*);

  assign bankRdata = bankMem[bankAddr[5:3]];
  always @(posedge clk) if (bankWr) bankMem[bankAddr[5:3]] <= bankWdata;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [ADDR_W-1:0] addr, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data;
    #1;
    seenRd = bankRd; seenWr = bankWr; seenBoth = bankRd & bankWr;
    seenAddr = bankAddr; seenWdata = bankWdata;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    gotValid = rspValid; gotData = rspData; gotErr = rspErr;
    check("R7 rspValid after request", gotValid, 1);
    check("R10 strobes exclusive", seenBoth, 0);
    @(negedge clk);
    #1;
    check("R7 rspValid drops", rspValid, 0);
  endtask

  task automatic testReset();
    #1;
    check("R1 rspValid", rspValid, 0);
    check("R1 rspData", rspData, 0);
    check("R1 rspErr", rspErr, 0);
    check("R10 no strobe idle", {bankRd, bankWr}, 0);
    access(0, 12'h01C, 0);
    check("R1 latch zero via high read", gotData, 0);
  endtask

  task automatic testLowWrite();
    access(1, 12'h010, 32'hCAFE_0001);
    check("R2 no read strobe", seenRd, 0);
    check("R2 no write strobe", seenWr, 0);
    check("R2 bank untouched", bankMem[2], 64'h2222_2222_2222_2222);
    access(0, 12'h034, 0);
    check("R6 high read returns written word", gotData, 32'hCAFE_0001);
    check("R5 no strobe on high read", {seenRd, seenWr}, 0);
  endtask

  task automatic testHighWrite();
    access(1, 12'h010, 32'h1111_AAAA);
    access(1, 12'h014, 32'h5555_BBBB);
    check("R3 write strobe", seenWr, 1);
    check("R3 bank address bit2 cleared", seenAddr, 12'h010);
    check("R3 write data", seenWdata, 64'h5555_BBBB_1111_AAAA);
    check("R3 bank content", bankMem[2], 64'h5555_BBBB_1111_AAAA);
  endtask

  task automatic testLowRead();
    access(0, 12'h018, 0);
    check("R4 read strobe", seenRd, 1);
    check("R4 bank address", seenAddr, 12'h018);
    check("R4 low word", gotData, 32'h3333_0003);
    access(0, 12'h01C, 0);
    check("R5 upper word from latch", gotData, 32'h3333_0033);
    check("R5 no strobe", {seenRd, seenWr}, 0);
  endtask

  task automatic testSnapshot();
    access(0, 12'h028, 0);
    check("R8 low word", gotData, 32'h5555_0005);
    bankMem[5] = 64'hDEAD_BEEF_0000_0000;
    access(0, 12'h02C, 0);
    check("R8 snapshot kept", gotData, 32'h5555_0055);
  endtask

  task automatic testMixed();
    access(0, 12'h008, 0);
    access(1, 12'h03C, 32'h7777_0777);
    check("R6 commit address", seenAddr, 12'h038);
    check("R6 commit uses read snapshot", bankMem[7], {32'h7777_0777, 32'h1111_0011});
    access(1, 12'h000, 32'h0F0F_0F0F);
    check("R7 write keeps rspData", gotData, 32'h1111_0001);
  endtask

  task automatic testErr();
    bankErr = 1'b1;
    access(0, 12'h000, 0);
    check("R9 error on bank read", gotErr, 1);
    access(0, 12'h004, 0);
    check("R9 no error on latch read", gotErr, 0);
    access(1, 12'h000, 32'h1);
    check("R9 no error on low write", gotErr, 0);
    access(1, 12'h004, 32'h2);
    check("R9 error on commit", gotErr, 1);
    bankErr = 1'b0;
    access(0, 12'h000, 0);
    check("R9 error cleared", gotErr, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) bankMem[i] = {2{16'(32'h1111 * i), 16'(i * 32'h11)}};
    bankMem[0] = 64'h1111_0011_1111_0001;
    bankMem[1] = 64'h1111_0011_1111_0001;
    bankMem[2] = 64'h2222_2222_2222_2222;
    bankMem[3] = 64'h3333_0033_3333_0003;
    bankMem[5] = 64'h5555_0055_5555_0005;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLowWrite();
    testHighWrite();
    testLowRead();
    testSnapshot();
    testMixed();
    testErr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule